// File: doc/BRIEF.md
# Parallel I/O Pin Controller

This block manages a bank of pins. Each pin is either handed to an on-chip peripheral or used as general-purpose I/O. In peripheral mode the peripheral's output value and output enable reach the pad, and the peripheral sees the pin's conditioned input. In general-purpose mode the pad is driven from software-owned output value and output-enable registers, and the peripheral input is held low.

Software reaches the block through a simple word-addressed register bus with single-cycle strobes and combinational read data. Each control register (mode, output enable, filter enable, output value, interrupt enable) has three addresses. The set address raises bits. The clear address lowers bits. The read address returns the stored value. A single bit can therefore change without a read-modify-write. Writing zero to a set or clear address leaves the register unchanged.

Each pin's input is sampled on the clock and can pass through an optional glitch filter. A change of the conditioned level on a pin whose interrupt is enabled latches a status bit. The status register clears when it is read. One interrupt line reports any pending enabled status bit.

Top module: `pio_bank`

## Requirements
- R1: After reset, every pin is in general-purpose mode (mode register all ones), and the output enable, output value, filter enable, interrupt enable and status registers are all zero, so `irq` is low.
- R2: The control register group is selected by address bits [4:2] (0 mode, 1 output enable, 2 filter enable, 3 output value, 4 interrupt enable). Bits [1:0] select the operation (0 set, 1 clear, 2 read). A write to a set address raises exactly the bits written as one and leaves every other bit unchanged.
- R3: A write to a clear address lowers exactly the bits written as one and leaves every other bit unchanged.
- R4: A read of a group's read address returns its stored value. Address 20 returns the conditioned input level of every pin. Address 21 returns the interrupt status.
- R5: A pin whose mode bit is 1 drives `pad_out`/`pad_oe` from the output value and output enable registers. A pin whose mode bit is 0 passes `per_out`/`per_oe` through.
- R6: `per_in` carries the conditioned level for a pin in peripheral mode and is 0 for a pin in general-purpose mode.
- R7: With its filter disabled, a pin's conditioned level equals the value `pad_in` had at the previous clock edge but one. A change is therefore visible after two edges.
- R8: With its filter enabled, a pin's conditioned level takes a new value only after `pad_in` has shown that value at two consecutive clock samples. A pulse lasting one clock cycle never reaches the conditioned level.
- R9: A change of a pin's conditioned level while its interrupt enable is 1 sets its status bit. `irq` is high exactly when some status bit is set together with its enable bit.
- R10: A read of address 21 returns the status and clears it, except for bits that are set by a change in that same cycle.
- R11: A pin whose interrupt enable is 0 never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid while a read is strobed |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| per_out | input | NPINS | Peripheral output values |
| per_oe | input | NPINS | Peripheral output enables |
| per_in | output | NPINS | Input levels delivered to peripherals |
| irq | output | 1 | Combined interrupt |

## Verification
The set and clear addresses are tried with sparse, dense and overlapping bit patterns. This shows that only the written ones change, and it separates the set path from the clear path. Pin inputs are given single-cycle glitches and held steps, each on filtered and on unfiltered pins. This separates the filter's hold-off from the plain sampling delay. Level changes are applied to pins with and without interrupt enable, and status reads are placed both after a change and on the same cycle as one. This shows gating, read-to-clear and the precedence of a fresh change. A behavioural reference model is compared on every clock for the pad, peripheral, interrupt and read-data outputs, with mixed mode patterns so that both mux directions are covered.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NREG     = 5;
  localparam int GRP_MODE = 0;
  localparam int GRP_OE   = 1;
  localparam int GRP_FLT  = 2;
  localparam int GRP_OUT  = 3;
  localparam int GRP_IEN  = 4;

  localparam logic [1:0] OP_SET = 2'd0;
  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;

  localparam int ADDR_LEVEL = 20;
  localparam int ADDR_STAT  = 21;

  // next value of one control bit under a set or clear write
  function automatic logic setclr_bit(input logic cur, input logic wd,
                                      input logic do_set, input logic do_clr);
    logic n;
    n = cur;
    if (do_set && wd) n = 1'b1;
    if (do_clr && wd) n = 1'b0;
    return n;
  endfunction

  // next conditioned level of one pin
  function automatic logic filt_bit(input logic cur, input logic s_new,
                                    input logic s_old, input logic fen);
    if (!fen) return s_new;
    if (s_new == s_old) return s_new;
    return cur;
  endfunction
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NPINS-1:0]            wdata,
  output logic [NREG-1:0][NPINS-1:0]  ctl
);
  localparam int GW = ADDR_W - 2;

  logic [NREG-1:0] hit_set;
  logic [NREG-1:0] hit_clr;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [NPINS-1:0] RST_VAL = (g == GRP_MODE) ? '1 : '0;

    assign hit_set[g] = wr_en && (addr[ADDR_W-1:2] == GW'(g)) && (addr[1:0] == OP_SET);
    assign hit_clr[g] = wr_en && (addr[ADDR_W-1:2] == GW'(g)) && (addr[1:0] == OP_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl[g] <= RST_VAL;
      end else begin
        for (int b = 0; b < NPINS; b++)
          ctl[g][b] <= setclr_bit(ctl[g][b], wdata[b], hit_set[g], hit_clr[g]);
      end
    end

    // R2: set address raises only written ones
    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set[g] |=> (ctl[g] == ($past(ctl[g]) | $past(wdata))));
    // R3: clear address lowers only written ones
    a_r3_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr[g] |=> (ctl[g] == ($past(ctl[g]) & ~$past(wdata))));
    // R2/R3: without a write the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_set[g] || hit_clr[g]) |=> $stable(ctl[g]));
  end
endmodule

// File: rtl/pio_infilter.sv
module pio_infilter
  import pio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] fen,
  output logic [NPINS-1:0] lvl
);
  logic [NPINS-1:0] samp_new;
  logic [NPINS-1:0] samp_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_new <= '0;
      samp_old <= '0;
      lvl      <= '0;
    end else begin
      samp_new <= pad_in;
      samp_old <= samp_new;
      for (int b = 0; b < NPINS; b++)
        lvl[b] <= filt_bit(lvl[b], samp_new[b], samp_old[b], fen[b]);
    end
  end

  // R8: a filtered pin only moves to a value seen at two consecutive samples
  a_r8_filter_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lvl ^ $past(lvl)) & $past(fen) & ($past(samp_new) ^ $past(samp_old))) == '0));
  // R7: an unfiltered pin follows the newest sample
  a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lvl ^ $past(samp_new)) & ~$past(fen)) == '0));
endmodule

// File: rtl/pio_chgdet.sv
module pio_chgdet #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] ien,
  input  logic             stat_rd,
  output logic [NPINS-1:0] stat,
  output logic [NPINS-1:0] chg_ev
);
  logic [NPINS-1:0] prev;

  assign chg_ev = (lvl ^ prev) & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      stat <= '0;
    end else begin
      prev <= lvl;
      stat <= (stat_rd ? '0 : stat) | chg_ev;
    end
  end

  // R10: a read with no fresh change leaves status empty
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (chg_ev == '0)) |=> (stat == '0));
  // R11: newly raised status bits had their enable set
  a_r11_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(ien)) == '0));
  // R9: without a read, pending bits stay pending
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  per_out,
  input  logic [NPINS-1:0]  per_oe,
  output logic [NPINS-1:0]  per_in,
  output logic              irq
);
  logic [NREG-1:0][NPINS-1:0] ctl;
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] stat;
  logic [NPINS-1:0] chg_ev;
  logic wr_en;
  logic rd_en;
  logic stat_rd;
  logic [NPINS-1:0] gp;

  assign wr_en   = bus_sel && bus_we;
  assign rd_en   = bus_sel && !bus_we;
  assign stat_rd = rd_en && (bus_addr == ADDR_W'(ADDR_STAT));
  assign gp      = ctl[GRP_MODE];

  pio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .ctl(ctl));

  pio_infilter #(.NPINS(NPINS)) u_filt (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .fen(ctl[GRP_FLT]), .lvl(lvl));

  pio_chgdet #(.NPINS(NPINS)) u_chg (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .ien(ctl[GRP_IEN]),
    .stat_rd(stat_rd), .stat(stat), .chg_ev(chg_ev));

  always_comb begin
    for (int b = 0; b < NPINS; b++) begin
      pad_out[b] = gp[b] ? ctl[GRP_OUT][b] : per_out[b];
      pad_oe[b]  = gp[b] ? ctl[GRP_OE][b]  : per_oe[b];
      per_in[b]  = gp[b] ? 1'b0 : lvl[b];
    end
  end

  assign irq = |(stat & ctl[GRP_IEN]);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      for (int g = 0; g < NREG; g++)
        if (bus_addr == ADDR_W'(g * 4 + 2)) bus_rdata = ctl[g];
      if (bus_addr == ADDR_W'(ADDR_LEVEL)) bus_rdata = lvl;
      if (bus_addr == ADDR_W'(ADDR_STAT))  bus_rdata = stat;
    end
  end

  // R9: interrupt only with a pending enabled bit
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat & ctl[GRP_IEN]) != '0));
  // R6: general-purpose pins deliver nothing to peripherals
  a_r6_gp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_in & gp) == '0));
  // R10: a fresh enabled change lands in status after the edge
  a_r10_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_ev != '0) |=> ((stat & $past(chg_ev)) == $past(chg_ev)));
endmodule

// File: tb/pio_bank_test.sv
module pio_bank_test;
  localparam int N  = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, pad_in = '0, per_out = '0, per_oe = '0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe, per_in;
  logic irq;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  pio_bank #(.NPINS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq));

  // behavioural reference: register array indexed by group, queue of input history
  logic [N-1:0] m_reg [5];
  logic [N-1:0] m_hist [$];
  logic [N-1:0] m_lvl, m_last, m_stat;

  task automatic model_reset();
    for (int g = 0; g < 5; g++) m_reg[g] = (g == 0) ? '1 : '0;
    m_hist = {};
    m_hist.push_back('0);
    m_hist.push_back('0);
    m_lvl = '0; m_last = '0; m_stat = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [N-1:0] nl, fresh;
      for (int b = 0; b < N; b++) begin
        if (!m_reg[2][b] || (m_hist[0][b] == m_hist[1][b])) nl[b] = m_hist[0][b];
        else nl[b] = m_lvl[b];
      end
      fresh = (m_lvl ^ m_last) & m_reg[4];
      if (bus_sel && !bus_we && bus_addr == 5'd21) m_stat = '0;
      m_stat = m_stat | fresh;
      m_last = m_lvl;
      m_lvl = nl;
      m_hist.push_front(pad_in);
      void'(m_hist.pop_back());
      if (bus_sel && bus_we && bus_addr[4:2] < 3'd5) begin
        if (bus_addr[1:0] == 2'd0) m_reg[bus_addr[4:2]] = m_reg[bus_addr[4:2]] | bus_wdata;
        if (bus_addr[1:0] == 2'd1) m_reg[bus_addr[4:2]] = m_reg[bus_addr[4:2]] & ~bus_wdata;
      end
    end
  end

  function automatic logic [N-1:0] m_read(input logic [AW-1:0] a);
    if (a == 5'd20) return m_lvl;
    if (a == 5'd21) return m_stat;
    if (a[4:2] < 3'd5 && a[1:0] == 2'd2) return m_reg[a[4:2]];
    return '0;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R5 pad_out", pad_out, (m_reg[0] & m_reg[3]) | (~m_reg[0] & per_out));
      check("R5 pad_oe", pad_oe, (m_reg[0] & m_reg[1]) | (~m_reg[0] & per_oe));
      check("R6 per_in", per_in, ~m_reg[0] & m_lvl);
      check("R9 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_stat & m_reg[4])});
      if (bus_sel && !bus_we) check("R4 rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_expect(input int a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    #2 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_expect(2, '1, "R1 mode after reset");
    rd_expect(6, '0, "R1 oe after reset");
    rd_expect(10, '0, "R1 filter after reset");
    rd_expect(14, '0, "R1 out after reset");
    rd_expect(18, '0, "R1 ien after reset");
    rd_expect(21, '0, "R1 status after reset");
    check("R1 irq after reset", {{(N-1){1'b0}}, irq}, '0);

    // R2 / R3 set and clear with zero bits having no effect
    wr(12, 32'hF0F0_00FF);
    rd_expect(14, 32'hF0F0_00FF, "R2 out set");
    wr(12, 32'h0000_0100);
    rd_expect(14, 32'hF0F0_01FF, "R2 set leaves other bits");
    wr(13, 32'h3000_000F);
    rd_expect(14, 32'hC0F0_01F0, "R3 clear only ones");
    wr(4, 32'hFFFF_0000);
    wr(5, 32'h0F00_0000);
    rd_expect(6, 32'hF0FF_0000, "R3 oe clear");

    // R5 / R6 peripheral mode on the low half
    per_out = 32'hA5A5_5A5A; per_oe = 32'h1234_8765;
    wr(1, 32'h0000_FFFF);
    rd_expect(2, 32'hFFFF_0000, "R3 mode clear");
    pad_in = 32'h0000_00C3;
    idle(3);
    check("R6 per_in peripheral pins", per_in, 32'h0000_00C3);
    check("R5 pad_out mix", pad_out, 32'hC0F0_5A5A);

    // R7 unfiltered level delay: visible after two edges
    pad_in = 32'h0000_0000;
    @(negedge clk); #2;
    check("R7 one edge not yet", per_in, 32'h0000_00C3);
    @(negedge clk); #2;
    check("R7 two edges", per_in, 32'h0000_0000);

    // R8 filter rejects one-cycle glitch on pin 3, passes held step
    wr(8, 32'h0000_0008);
    wr(16, 32'h0000_0028);
    idle(3);
    rd_expect(21, '0, "R8 status clean before glitch");
    @(negedge clk); pad_in = 32'h0000_0008;
    @(negedge clk); pad_in = 32'h0000_0000;
    idle(4);
    rd_expect(20, 32'h0000_0000, "R8 glitch blocked");
    rd_expect(21, '0, "R8 glitch raises no status");
    @(negedge clk); pad_in = 32'h0000_0008;
    @(negedge clk); #2;
    check("R8 filtered after one edge", per_in, '0);
    @(negedge clk); #2;
    check("R8 filtered after two edges", per_in, '0);
    @(negedge clk); #2;
    check("R8 filtered after three edges", per_in, 32'h0000_0008);
    idle(2);
    rd_expect(21, 32'h0000_0008, "R10 status read returns bit3");
    rd_expect(21, '0, "R10 status cleared");

    // R9 unfiltered pin 5 change raises irq; R11 pin 7 without enable
    pad_in = 32'h0000_00A8;
    idle(4);
    check("R9 irq high", {{(N-1){1'b0}}, irq}, 32'h1);
    rd_expect(21, 32'h0000_0020, "R11 pin7 absent, pin5 present");
    check("R10 irq low after read", {{(N-1){1'b0}}, irq}, '0);

    // R10 change in the same cycle as the read survives
    @(negedge clk); pad_in = 32'h0000_0088;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'd21;
    @(negedge clk); bus_sel = 1'b0;
    #2 check("R10 same-cycle change kept", {{(N-1){1'b0}}, irq}, 32'h1);
    rd_expect(21, 32'h0000_0020, "R10 kept bit reads back");

    // R5 back to general-purpose
    wr(0, 32'h0000_FFFF);
    #2 check("R5 gp out", pad_out, 32'hC0F0_01F0);
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule